// File: doc/BRIEF.md
# Bus Address Remapping Bridge

This bridge sits between one master port and one slave port of a single-cycle handshake bus with 32-bit data and 32-bit addresses. It rewrites the address of every bus cycle on its way from master to slave. Cycle, strobe, write enable, byte selects, write data, read data, acknowledge and error all pass straight through. The address path is purely combinational, so the bridge adds no cycle of latency.

The address goes through two optional stages. The fold stage reduces the address modulo a power-of-two window and adds a fixed base. The region stage then compares the folded address against a table of source regions. A hit is replaced by the paired destination base plus the offset inside the region. A miss leaves the address unchanged. A parameter selects byte or word address units. In word units every base, window and region size is divided by four inside the block, so the same mapping holds on word addresses. All bases, sizes and enables are fixed at elaboration. The block has no clock and no stored state.

Top module: `bus_addr_remap`

## Requirements
- R1: With the fold stage enabled, the folded address equals the fold base plus the incoming address modulo 2^WIN_LOG2. With base 0x0001_0000 and window 0x1000_0000, master addresses 0x0000_0004 and 0x1000_0004 both reach the slave as 0x0001_0004.
- R2: An address inside source region i (base SRC_BASE[i], size 2^REG_LOG2[i]) leaves as DST_BASE[i] plus its offset inside that region.
- R3: An address that hits no source region leaves the region stage unchanged. With the default table, master address 0x0002_0000 folds to 0x0003_0000 and is emitted as 0x0003_0000.
- R4: When both stages are enabled, the fold is applied first and the table is applied to its result. With the defaults, master address 0x0 is emitted as 0x1000_0000.
- R5: When source regions overlap, the lowest-indexed matching region decides the result.
- R6: With ADDR_UNIT set to word, every base, window and region size is taken as a byte quantity divided by 4. The word address w is then emitted as (the byte-mode result for 4*w) divided by 4.
- R7: cyc, stb, we, sel and write data go from master to slave unchanged. Read data, ack and err go from slave to master unchanged.
- R8: The slave address follows the master address in the same cycle with no register on the path. Back-to-back cycles therefore appear on the slave one per clock, in order.
- R9: A stage whose enable parameter is 0 passes the address through unchanged. With only the fold stage enabled, the output is exactly the result of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_cyc | input | 1 | Master cycle-valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_sel | input | DATA_W/8 | Master byte selects |
| m_adr | input | ADDR_W | Master address |
| m_wdat | input | DATA_W | Master write data |
| m_rdat | output | DATA_W | Read data returned to the master |
| m_ack | output | 1 | Acknowledge returned to the master |
| m_err | output | 1 | Error returned to the master |
| s_cyc | output | 1 | Slave cycle-valid |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_sel | output | DATA_W/8 | Slave byte selects |
| s_adr | output | ADDR_W | Remapped slave address |
| s_wdat | output | DATA_W | Slave write data |
| s_rdat | input | DATA_W | Slave read data |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle as the address that triggers it. A wrong window mask shows as a wrong high-order bit on the slave address. A wrong region compare or a broken priority chain shows as the wrong destination base, or as no translation where one is due. The bench checks three configurations (both stages in byte units, both stages in word units, fold only) against a behavioural model on every clock, using directed edge addresses and random ones.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic {
        UNIT_BYTE = 1'b0,
        UNIT_WORD = 1'b1
    } addr_unit_e;

    // right shift that turns a byte quantity into the selected unit
    function automatic int unit_shift(addr_unit_e u);
        return (u == UNIT_WORD) ? 2 : 0;
    endfunction

    // n low bits set
    function automatic logic [63:0] low_mask(int n);
        if (n <= 0)  return 64'd0;
        if (n >= 64) return {64{1'b1}};
        return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/remap_fold.sv
module remap_fold
    import remap_pkg::*;
#(
    parameter int            ADDR_W   = 32,
    parameter addr_unit_e    UNIT     = UNIT_BYTE,
    parameter bit            FOLD_EN  = 1'b1,
    parameter logic [31:0]   ORIGIN   = 32'h0001_0000,
    parameter int            WIN_LOG2 = 19
) (
    input  logic [ADDR_W-1:0] in_adr,
    output logic [ADDR_W-1:0] out_adr
);

    generate
        if (FOLD_EN) begin : g_fold
            localparam int              SH       = unit_shift(UNIT);
            localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(low_mask(WIN_LOG2 - SH));
            localparam logic [ADDR_W-1:0] ORG_U    = ADDR_W'(ORIGIN >> SH);

            assign out_adr = ORG_U + (in_adr & WIN_MASK);

            // R1: result never leaves the window above the base
            always_comb begin
                if (!$isunknown(in_adr)) begin
                    a_r1_inside_window: assert (((out_adr - ORG_U) & ~WIN_MASK) == '0)
                        else $error("fold result left the window");
                end
            end
        end else begin : g_bypass
            // R9: stage disabled
            assign out_adr = in_adr;
        end
    endgenerate

endmodule

// File: rtl/remap_region.sv
module remap_region
    import remap_pkg::*;
#(
    parameter int                       ADDR_W    = 32,
    parameter addr_unit_e               UNIT      = UNIT_BYTE,
    parameter bit                       REGION_EN = 1'b1,
    parameter int                       N_REG     = 4,
    parameter logic [N_REG-1:0][31:0]   SRC_BASE  = '0,
    parameter logic [N_REG-1:0][31:0]   DST_BASE  = '0,
    parameter logic [N_REG-1:0][7:0]    REG_LOG2  = '0
) (
    input  logic [ADDR_W-1:0] in_adr,
    output logic [ADDR_W-1:0] out_adr
);

    generate
        if (REGION_EN) begin : g_table
            localparam int SH = unit_shift(UNIT);

            logic [N_REG-1:0]             hit;
            logic [N_REG-1:0]             grant;
            logic [N_REG-1:0][ADDR_W-1:0] xlat;
            logic [N_REG-1:0][ADDR_W-1:0] offs_mask;

            for (genvar i = 0; i < N_REG; i++) begin : g_entry
                localparam logic [ADDR_W-1:0] MI    = ADDR_W'(low_mask(int'(REG_LOG2[i]) - SH));
                localparam logic [ADDR_W-1:0] SRC_U = ADDR_W'(SRC_BASE[i] >> SH);
                localparam logic [ADDR_W-1:0] DST_U = ADDR_W'(DST_BASE[i] >> SH);

                assign hit[i]       = ((in_adr & ~MI) == (SRC_U & ~MI));
                assign xlat[i]      = DST_U + (in_adr & MI);
                assign offs_mask[i] = MI;
            end

            // R5: priority pick, lowest index wins
            always_comb begin
                logic found;
                found   = 1'b0;
                grant   = '0;
                out_adr = in_adr;
                for (int k = 0; k < N_REG; k++) begin
                    if (hit[k] && !found) begin
                        found    = 1'b1;
                        grant[k] = 1'b1;
                        out_adr  = xlat[k];
                    end
                end
            end

            always_comb begin
                if (!$isunknown(in_adr)) begin
                    // R5: at most one region selected
                    a_r5_single_grant: assert ($onehot0(grant))
                        else $error("more than one region granted");
                    // R3: a miss leaves the address alone
                    if (hit == '0) begin
                        a_r3_miss_unchanged: assert (out_adr == in_adr)
                            else $error("missed address altered");
                    end
                    for (int k = 0; k < N_REG; k++) begin
                        if (grant[k]) begin
                            // R5: no lower region also matched
                            a_r5_lowest_first: assert ((hit & N_REG'((1 << k) - 1)) == '0)
                                else $error("lower region skipped");
                            // R2: offset bits survive translation
                            a_r2_offset_kept: assert ((out_adr & offs_mask[k]) == (in_adr & offs_mask[k]))
                                else $error("region offset lost");
                        end
                    end
                end
            end
        end else begin : g_bypass
            // R9: stage disabled
            assign out_adr = in_adr;
        end
    endgenerate

endmodule

// File: rtl/bus_addr_remap.sv
module bus_addr_remap
    import remap_pkg::*;
#(
    parameter int                      ADDR_W    = 32,
    parameter int                      DATA_W    = 32,
    parameter addr_unit_e              ADDR_UNIT = UNIT_BYTE,
    parameter bit                      FOLD_EN   = 1'b1,
    parameter logic [31:0]             ORIGIN    = 32'h0001_0000,
    parameter int                      WIN_LOG2  = 19,
    parameter bit                      REGION_EN = 1'b1,
    parameter int                      N_REG     = 4,
    // entries listed highest index first
    parameter logic [N_REG-1:0][31:0]  SRC_BASE  = {32'h0005_0000, 32'h0001_0000, 32'h0004_0000, 32'h0001_0000},
    parameter logic [N_REG-1:0][31:0]  DST_BASE  = {32'h3000_0000, 32'h4000_0000, 32'h2000_0000, 32'h1000_0000},
    parameter logic [N_REG-1:0][7:0]   REG_LOG2  = {8'd13, 8'd12, 8'd12, 8'd12}
) (
    input  logic                  m_cyc,
    input  logic                  m_stb,
    input  logic                  m_we,
    input  logic [DATA_W/8-1:0]   m_sel,
    input  logic [ADDR_W-1:0]     m_adr,
    input  logic [DATA_W-1:0]     m_wdat,
    output logic [DATA_W-1:0]     m_rdat,
    output logic                  m_ack,
    output logic                  m_err,
    output logic                  s_cyc,
    output logic                  s_stb,
    output logic                  s_we,
    output logic [DATA_W/8-1:0]   s_sel,
    output logic [ADDR_W-1:0]     s_adr,
    output logic [DATA_W-1:0]     s_wdat,
    input  logic [DATA_W-1:0]     s_rdat,
    input  logic                  s_ack,
    input  logic                  s_err
);

    logic [ADDR_W-1:0] folded_adr;

    // R4: fold first, table second
    remap_fold #(
        .ADDR_W   (ADDR_W),
        .UNIT     (ADDR_UNIT),
        .FOLD_EN  (FOLD_EN),
        .ORIGIN   (ORIGIN),
        .WIN_LOG2 (WIN_LOG2)
    ) fold_i (
        .in_adr  (m_adr),
        .out_adr (folded_adr)
    );

    remap_region #(
        .ADDR_W    (ADDR_W),
        .UNIT      (ADDR_UNIT),
        .REGION_EN (REGION_EN),
        .N_REG     (N_REG),
        .SRC_BASE  (SRC_BASE),
        .DST_BASE  (DST_BASE),
        .REG_LOG2  (REG_LOG2)
    ) region_i (
        .in_adr  (folded_adr),
        .out_adr (s_adr)
    );

    // R7: everything but the address passes through
    assign s_cyc  = m_cyc;
    assign s_stb  = m_stb;
    assign s_we   = m_we;
    assign s_sel  = m_sel;
    assign s_wdat = m_wdat;
    assign m_rdat = s_rdat;
    assign m_ack  = s_ack;
    assign m_err  = s_err;

endmodule

// File: tb/bus_addr_remap_tb_top.sv
module bus_addr_remap_tb_top;
    import remap_pkg::*;

    logic clk = 1'b0;
    always #4ns clk = ~clk;   // 125 MHz

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // shared master-side and slave-side stimulus
    logic        m_cyc = 0, m_stb = 0, m_we = 0;
    logic [3:0]  m_sel = 0;
    logic [31:0] m_wdat = 0, s_rdat = 0;
    logic        s_ack = 0, s_err = 0;
    logic [31:0] adr_b = 0;   // byte address to combined and fold-only units
    logic [31:0] adr_w = 0;   // word address to word-unit instance

    // outputs per instance
    logic [31:0] rd_b, rd_w, rd_o, sa_b, sa_w, sa_o, sw_b, sw_w, sw_o;
    logic        ak_b, ak_w, ak_o, er_b, er_w, er_o;
    logic        sc_b, sc_w, sc_o, ss_b, ss_w, ss_o, sv_b, sv_w, sv_o;
    logic [3:0]  sl_b, sl_w, sl_o;

    bus_addr_remap dut_i (
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_sel(m_sel), .m_adr(adr_b), .m_wdat(m_wdat),
        .m_rdat(rd_b), .m_ack(ak_b), .m_err(er_b),
        .s_cyc(sc_b), .s_stb(ss_b), .s_we(sv_b), .s_sel(sl_b), .s_adr(sa_b), .s_wdat(sw_b),
        .s_rdat(s_rdat), .s_ack(s_ack), .s_err(s_err));

    bus_addr_remap #(.ADDR_UNIT(UNIT_WORD)) dut_w (
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_sel(m_sel), .m_adr(adr_w), .m_wdat(m_wdat),
        .m_rdat(rd_w), .m_ack(ak_w), .m_err(er_w),
        .s_cyc(sc_w), .s_stb(ss_w), .s_we(sv_w), .s_sel(sl_w), .s_adr(sa_w), .s_wdat(sw_w),
        .s_rdat(s_rdat), .s_ack(s_ack), .s_err(s_err));

    bus_addr_remap #(.ORIGIN(32'h0001_0000), .WIN_LOG2(28), .REGION_EN(1'b0)) dut_o (
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_sel(m_sel), .m_adr(adr_b), .m_wdat(m_wdat),
        .m_rdat(rd_o), .m_ack(ak_o), .m_err(er_o),
        .s_cyc(sc_o), .s_stb(ss_o), .s_we(sv_o), .s_sel(sl_o), .s_adr(sa_o), .s_wdat(sw_o),
        .s_rdat(s_rdat), .s_ack(s_ack), .s_err(s_err));

    // behavioural reference: byte units, combined or fold-only
    function automatic logic [31:0] ref_map(logic [31:0] a, bit combined);
        longint unsigned src[4] = '{64'h1_0000, 64'h4_0000, 64'h1_0000, 64'h5_0000};
        longint unsigned dst[4] = '{64'h1000_0000, 64'h2000_0000, 64'h4000_0000, 64'h3000_0000};
        longint unsigned sz[4]  = '{64'h1000, 64'h1000, 64'h1000, 64'h2000};
        longint unsigned x;
        if (!combined) return 32'(64'h1_0000 + (longint'(a) % 64'h1000_0000));
        x = 64'h1_0000 + (longint'(a) % 64'h8_0000);
        for (int k = 0; k < 4; k++)
            if (x >= src[k] && x < src[k] + sz[k]) return 32'(dst[k] + (x - src[k]));
        return 32'(x);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] a4;
        a4 = adr_w << 2;
        chk({tag, " byte"}, sa_b, ref_map(adr_b, 1'b1));
        chk({"R6 ", tag, " word"}, sa_w, ref_map(a4, 1'b1) >> 2);
        chk("R9 fold only", sa_o, ref_map(adr_b, 1'b0));
        chk("R7 to slave", {sc_b, ss_b, sv_b, sl_b, sw_b[27:0]}, {m_cyc, m_stb, m_we, m_sel, m_wdat[27:0]});
        chk("R7 to slave hi", {sw_w[31:28], sw_o[31:28], sc_w, sc_o}, {m_wdat[31:28], m_wdat[31:28], m_cyc, m_cyc});
        chk("R7 to master", rd_b ^ rd_w ^ rd_o, s_rdat);
        chk("R7 ack/err", {ak_b, ak_w, ak_o, er_b, er_w, er_o}, {{3{s_ack}}, {3{s_err}}});
    endtask

    task automatic apply(logic [31:0] a, string tag);
        @(posedge clk);
        #1ns;
        adr_b  = a;
        adr_w  = a >> 2;
        m_cyc  = 1'b1;
        m_stb  = 1'b1;
        m_we   = $urandom_range(0, 1);
        m_sel  = 4'($urandom);
        m_wdat = $urandom;
        s_rdat = $urandom;
        s_ack  = 1'b1;
        s_err  = $urandom_range(0, 1);
        @(negedge clk);   // R8: same cycle, no register on the path
        check_all(tag);
    endtask

    initial begin
        @(negedge clk);
        // idle state: controls low, address 0 maps through both stages
        chk("R7 idle cyc", {sc_b, ss_b, ak_b}, 3'b000);
        chk("R4 idle adr", sa_b, 32'h1000_0000);

        apply(32'h0000_0000, "R4 zero");
        chk("R4 literal", sa_b, 32'h1000_0000);
        apply(32'h0002_0000, "R3 miss");
        chk("R3 literal", sa_b, 32'h0003_0000);
        apply(32'h0000_0004, "R5 overlap");
        chk("R5 literal", sa_b, 32'h1000_0004);
        apply(32'h0003_0008, "R2 region1");
        chk("R2 literal", sa_b, 32'h2000_0008);
        apply(32'h0004_1ff0, "R2 big region");
        chk("R2 big literal", sa_b, 32'h3000_1ff0);
        apply(32'h0004_2000, "R3 past region end");
        apply(32'h0008_0010, "R1 wrap");
        chk("R1 wrap literal", sa_b, 32'h1000_0010);
        apply(32'h1000_0004, "R1 high");
        chk("R1 fold only literal", sa_o, 32'h0001_0004);
        chk("R6 word literal", sa_w, 32'h1000_0004 >> 2 == 0 ? 0 : ref_map(32'h1000_0004, 1'b1) >> 2);
        apply(32'h0000_0004, "R1 low");
        chk("R1 fold only low", sa_o, 32'h0001_0004);
        apply(32'hffff_fffc, "R1 top");
        // R8: back-to-back single writes, one per clock
        for (int n = 0; n < 8; n++) apply(32'h0000_0000 + 32'(n * 4), "R8 burst");
        for (int n = 0; n < 80; n++) apply($urandom, "R4 random");
        for (int n = 0; n < 40; n++) apply(32'($urandom_range(0, 32'h0007_ffff)) & 32'hffff_fffc, "R2 dense");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule